// File: doc/BRIEF.md
# Serial Flash Command-less Read Controller

This block sits on the host side of a serial NOR flash and turns parallel read requests (start address and byte count) into flash read transactions on one, two or four data lines. Each transaction asserts chip select, shifts out an optional command byte and the address most-significant bit first, runs a programmable number of dummy clocks, and then gathers the returned bytes. The serial clock runs at half the system clock and rests low between transactions.

The controller tracks whether the flash is in command-less read mode. A configuration request writes the flash's volatile configuration register with its enable bit (bit 3) cleared. The next read then drives a confirmation bit of 0 on DQ0 in the first dummy clock, which puts the flash into the mode. After that, reads carry only the address. A read flagged as an exit drives the confirmation bit to 1. The controller then drops the mode, sets its shadow copy of bit 3 back to 1, and sends the command byte again on every later read. A strap input starts the controller already in the mode, which matches a flash that was configured to power up that way. After reset, chip select stays high for a supply-to-select delay.

Top module: `xip_read_ctrl`

## Requirements
- R1: After reset, `cs_n` stays high and `req_ready` stays low for `PWRUP_CYCLES` clocks. Once that delay has passed, `req_ready` goes high.
- R2: A read made outside the mode sends command byte 0x0B, then the `ADDR_W`-bit address MSB first, then `dummy_clks` dummy clocks, then the data. A `dummy_clks` value of 0 is treated as 1.
- R3: A request with `req_cfg` high sends command byte 0x81 followed by one data byte equal to `VCR_IMAGE` with bit 3 cleared (0xF3 by default). When it completes, `vcr_xip_n` is 0. No address or dummy clocks are sent.
- R4: In the first dummy clock of every read, DQ0 is driven with the confirmation bit. The bit is 0 when `vcr_xip_n` is 0 and `req_exit` is low, and 1 otherwise. In that clock, `dq_oe` is 4'b0001.
- R5: A read that sends a confirmation bit of 0 while `vcr_xip_n` is 0 sets `xip_active`. While `xip_active` is set, reads send the address without a command byte.
- R6: A read that sends a confirmation bit of 1 clears `xip_active` and sets `vcr_xip_n` to 1. Every later read sends the command byte again.
- R7: With `strap_xip_boot` high during reset, the controller leaves reset with `xip_active`=1 and `vcr_xip_n`=0. Its first read carries no command byte.
- R8: The `lanes` input selects the line count: 0 gives one line (out on DQ0, in on DQ1), 1 gives two lines (DQ1 carries the higher bit), and 2 or 3 give four lines (DQ3 carries the highest bit). The command, address and data all use the selected line count.
- R9: A read returns exactly `req_len` bytes (1 to 255). Each byte arrives as a one-cycle `rd_valid` pulse with `rd_data`, MSB first, in address order.
- R10: `busy` is high exactly while `cs_n` is low. `req_ready` is high only while idle. `sck` is low whenever `cs_n` is high (clock mode 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_xip_boot | input | 1 | Start in command-less read mode after reset |
| lanes | input | 2 | Line count select: 0 = one, 1 = two, 2/3 = four |
| dummy_clks | input | DUMMY_W | Dummy clocks per read |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_cfg | input | 1 | Request is a volatile configuration write that enables the mode |
| req_exit | input | 1 | Read leaves the mode (confirmation bit 1) |
| req_addr | input | ADDR_W | Read start address |
| req_len | input | LEN_W | Number of bytes to read |
| rd_valid | output | 1 | Read byte valid pulse |
| rd_data | output | 8 | Read byte |
| busy | output | 1 | Chip select asserted |
| xip_active | output | 1 | Flash is in command-less read mode |
| vcr_xip_n | output | 1 | Shadow of volatile configuration bit 3 (0 = mode enabled) |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| dq_out | output | 4 | Data lines driven toward the flash |
| dq_oe | output | 4 | Per-line output enable |
| dq_in | input | 4 | Data lines from the flash |

## Verification
The hardest state to reach from the ports is a long chain of mode transitions. To get there, a configuration write must land first, the next read must carry a 0 confirmation bit, and the command-less reads that follow must come out right even while the line count and dummy length change between them. The bench drives a behavioural flash model that keeps its own mode flag and configuration bit and decodes each transaction from the pins alone. It runs the full chain (enable, confirm, three command-less reads on different line counts, exit, normal read), then resets with the strap high and runs it again from the powered-up mode. After each transaction it compares the command, address, confirmation bit and mode flags that the model saw against the expected values.

// File: rtl/xip_pkg.sv
// Shared types and constants for the command-less read controller.
// Assumes command codes are fixed for the fast-read family.
package xip_pkg;
    typedef enum logic [2:0] {
        ST_PWR   = 3'd0,
        ST_IDLE  = 3'd1,
        ST_CMD   = 3'd2,
        ST_ADDR  = 3'd3,
        ST_DUMMY = 3'd4,
        ST_DATA  = 3'd5,
        ST_WDATA = 3'd6,
        ST_END   = 3'd7
    } xip_state_e;

    localparam logic [7:0] OP_FAST_READ = 8'h0B;
    localparam logic [7:0] OP_WRITE_VCR = 8'h81;
endpackage

// File: rtl/xip_pwrup_timer.sv
// Supply-to-select delay: holds ready low for CYCLES clocks after reset.
// Assumes CYCLES >= 1.
module xip_pwrup_timer #(
    parameter int CYCLES = 12500
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] cnt_q;

    // Count up once after reset and latch completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            done  <= 1'b0;
        end else if (!done) begin
            if (cnt_q == CW'(CYCLES - 1)) done  <= 1'b1;
            else                          cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/xip_lane_shifter.sv
// Serial shifter for 1/2/4 lanes: MSB-first transmit, receive byte assembly.
// Assumes lg (log2 of line count) is stable inside a transaction.
module xip_lane_shifter #(
    parameter int SR_W = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      lg,
    input  logic            load,
    input  logic [SR_W-1:0] load_val,
    input  logic            shift,
    input  logic            sample,
    input  logic [3:0]      dq_in,
    output logic [3:0]      dq_tx,
    output logic [7:0]      rx_byte
);
    logic [SR_W-1:0] tx_q;

    // Transmit register: load a field or advance by the line count.
    always_ff @(posedge clk) begin
        if (!rst_n)     tx_q <= '0;
        else if (load)  tx_q <= load_val;
        else if (shift) tx_q <= tx_q << (1 << lg);
    end

    // Present the top bits of the transmit register on the active lines.
    always_comb begin
        case (lg)
            2'd0:    dq_tx = {3'b000, tx_q[SR_W-1]};
            2'd1:    dq_tx = {2'b00, tx_q[SR_W-1 -: 2]};
            default: dq_tx = tx_q[SR_W-1 -: 4];
        endcase
    end

    // Receive register: shift in sampled lines, single line arrives on DQ1.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_byte <= '0;
        else if (sample) begin
            case (lg)
                2'd0:    rx_byte <= {rx_byte[6:0], dq_in[1]};
                2'd1:    rx_byte <= {rx_byte[5:0], dq_in[1:0]};
                default: rx_byte <= {rx_byte[3:0], dq_in};
            endcase
        end
    end
endmodule

// File: rtl/xip_mode_tracker.sv
// Tracks command-less read mode and the shadow of configuration bit 3.
// Assumes conf_fire pulses once per read, in the clock the flash samples it.
module xip_mode_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic strap,
    input  logic cfg_done,
    input  logic conf_fire,
    input  logic conf_bit,
    output logic xip_active,
    output logic vcr_xip_n
);
    // Update mode and shadow bit from config writes and confirmation bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xip_active <= strap;
            vcr_xip_n  <= !strap;
        end else if (cfg_done) begin
            vcr_xip_n <= 1'b0;
        end else if (conf_fire) begin
            if (conf_bit) begin
                xip_active <= 1'b0;
                vcr_xip_n  <= 1'b1;
            end else if (!vcr_xip_n) begin
                xip_active <= 1'b1;
            end
        end
    end

    // R6
    exit_clears_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conf_fire && conf_bit && !cfg_done) |=> (!xip_active && vcr_xip_n));

    // R5
    entry_needs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!xip_active ##1 xip_active) |-> $past(conf_fire && !conf_bit));
endmodule

// File: rtl/xip_read_ctrl.sv
// Host-side serial flash read controller with command-less read mode.
// Sequences command/address/dummy/data phases at half the system clock
// (mode 0), skips the command while the mode is active. Assumes ADDR_W is a
// multiple of 4 and at least 8, and req_len is non-zero.
module xip_read_ctrl
    import xip_pkg::*;
#(
    parameter int         ADDR_W       = 24,
    parameter int         LEN_W        = 8,
    parameter int         DUMMY_W      = 4,
    parameter int         PWRUP_CYCLES = 12500,
    parameter logic [7:0] VCR_IMAGE    = 8'hFB
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strap_xip_boot,
    input  logic [1:0]         lanes,
    input  logic [DUMMY_W-1:0] dummy_clks,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_cfg,
    input  logic               req_exit,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [LEN_W-1:0]   req_len,
    output logic               rd_valid,
    output logic [7:0]         rd_data,
    output logic               busy,
    output logic               xip_active,
    output logic               vcr_xip_n,
    output logic               sck,
    output logic               cs_n,
    output logic [3:0]         dq_out,
    output logic [3:0]         dq_oe,
    input  logic [3:0]         dq_in
);
    localparam int         CNT_W   = $clog2(ADDR_W) + 1;
    localparam int         PAD_W   = ADDR_W - 8;
    localparam logic [7:0] VCR_ON  = VCR_IMAGE & 8'hF7;

    xip_state_e         state;
    logic               ph, first_dummy, cfg_q, conf_q, data_last, emit_q;
    logic [1:0]         lg_q;
    logic [CNT_W-1:0]   cnt;
    logic [DUMMY_W-1:0] dummy_q;
    logic [LEN_W-1:0]   bytes_left;
    logic [2:0]         slot;
    logic [ADDR_W-1:0]  addr_q, sh_val;
    logic [3:0]         dq_tx;
    logic               pwr_ok, acc, need_cmd, active, fall, sh_load, sh_shift;
    logic               sample, conf_fire, cfg_done;
    logic [1:0]         lg_in;

    assign lg_in = lanes[1] ? 2'd2 : lanes;

    // Decode phase events that steer the shifter and the mode tracker.
    always_comb begin
        acc       = (state == ST_IDLE) && req_valid;
        need_cmd  = req_cfg || !xip_active;
        active    = state inside {ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA, ST_WDATA};
        fall      = active && ph;
        sh_load   = acc || (fall && cnt == '0 && state == ST_CMD);
        sh_shift  = fall && cnt != '0 && state inside {ST_CMD, ST_ADDR, ST_WDATA};
        sample    = (state == ST_DATA) && !ph;
        conf_fire = (state == ST_DUMMY) && !ph && first_dummy;
        cfg_done  = (state == ST_WDATA) && ph && cnt == '0;
        if (acc) sh_val = need_cmd ? {(req_cfg ? OP_WRITE_VCR : OP_FAST_READ), {PAD_W{1'b0}}}
                                   : req_addr;
        else     sh_val = cfg_q ? {VCR_ON, {PAD_W{1'b0}}} : addr_q;
    end

    // Phase sequencer, serial clock generator and byte framing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_PWR;  ph <= 1'b0;  sck <= 1'b0;  cs_n <= 1'b1;
            cnt <= '0;  first_dummy <= 1'b0;  cfg_q <= 1'b0;  conf_q <= 1'b1;
            lg_q <= '0;  dummy_q <= '0;  bytes_left <= '0;  slot <= '0;
            addr_q <= '0;  data_last <= 1'b0;  emit_q <= 1'b0;
        end else begin
            emit_q <= 1'b0;
            case (state)
                ST_PWR:  if (pwr_ok) state <= ST_IDLE;
                ST_END:  state <= ST_IDLE;
                ST_IDLE: if (req_valid) begin
                    lg_q       <= lg_in;
                    dummy_q    <= (dummy_clks == '0) ? DUMMY_W'(1) : dummy_clks;
                    cfg_q      <= req_cfg;
                    conf_q     <= req_exit || vcr_xip_n;
                    bytes_left <= req_len;
                    addr_q     <= req_addr;
                    slot       <= '0;
                    data_last  <= 1'b0;
                    cs_n       <= 1'b0;
                    ph         <= 1'b0;
                    if (need_cmd) begin
                        state <= ST_CMD;
                        cnt   <= CNT_W'((8 >> lg_in) - 1);
                    end else begin
                        state <= ST_ADDR;
                        cnt   <= CNT_W'((ADDR_W >> lg_in) - 1);
                    end
                end
                default: if (!ph) begin
                    sck <= 1'b1;
                    ph  <= 1'b1;
                    if (state == ST_DATA) begin
                        if (slot == 3'((8 >> lg_q) - 1)) begin
                            slot       <= '0;
                            emit_q     <= 1'b1;
                            bytes_left <= bytes_left - 1'b1;
                            if (bytes_left == LEN_W'(1)) data_last <= 1'b1;
                        end else begin
                            slot <= slot + 1'b1;
                        end
                    end
                end else begin
                    sck         <= 1'b0;
                    ph          <= 1'b0;
                    first_dummy <= 1'b0;
                    if (state == ST_DATA) begin
                        if (data_last) begin
                            cs_n  <= 1'b1;
                            state <= ST_END;
                        end
                    end else if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        case (state)
                            ST_CMD: begin
                                state <= cfg_q ? ST_WDATA : ST_ADDR;
                                cnt   <= cfg_q ? CNT_W'((8 >> lg_q) - 1)
                                               : CNT_W'((ADDR_W >> lg_q) - 1);
                            end
                            ST_ADDR: begin
                                state       <= ST_DUMMY;
                                cnt         <= CNT_W'(dummy_q - 1'b1);
                                first_dummy <= 1'b1;
                            end
                            ST_DUMMY: state <= ST_DATA;
                            default: begin
                                cs_n  <= 1'b1;
                                state <= ST_END;
                            end
                        endcase
                    end
                end
            endcase
        end
    end

    // Line drivers: shifted field, or confirmation bit in the first dummy clock.
    always_comb begin
        dq_out = dq_tx;
        dq_oe  = 4'b0000;
        if (state inside {ST_CMD, ST_ADDR, ST_WDATA})
            dq_oe = (lg_q == 2'd0) ? 4'b0001 : (lg_q == 2'd1) ? 4'b0011 : 4'b1111;
        else if (state == ST_DUMMY) begin
            dq_out = {3'b000, conf_q};
            if (first_dummy) dq_oe = 4'b0001;
        end
    end

    assign req_ready = (state == ST_IDLE);
    assign busy      = !cs_n;
    assign rd_valid  = emit_q;

    xip_pwrup_timer #(.CYCLES(PWRUP_CYCLES)) u_pwr (
        .clk(clk), .rst_n(rst_n), .done(pwr_ok));

    xip_lane_shifter #(.SR_W(ADDR_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .lg(lg_q), .load(sh_load), .load_val(sh_val),
        .shift(sh_shift), .sample(sample), .dq_in(dq_in), .dq_tx(dq_tx),
        .rx_byte(rd_data));

    xip_mode_tracker u_mode (
        .clk(clk), .rst_n(rst_n), .strap(strap_xip_boot), .cfg_done(cfg_done),
        .conf_fire(conf_fire), .conf_bit(conf_q), .xip_active(xip_active),
        .vcr_xip_n(vcr_xip_n));

    // R1
    no_select_before_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |-> cs_n);

    // R10
    clock_idles_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    // R10
    ready_only_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> cs_n);

    // R9
    data_inside_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !cs_n);
endmodule

// File: tb/xip_read_ctrl_tb.sv
// Scoreboard bench with a behavioural flash model decoding the pins.
module xip_read_ctrl_tb;
    localparam int PWR = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap = 1'b0;
    logic [1:0]  lanes = 2'd0;
    logic [3:0]  dummy = 4'd8;
    logic        req_valid = 1'b0, req_cfg = 1'b0, req_exit = 1'b0;
    logic [23:0] req_addr = '0;
    logic [7:0]  req_len = 8'd1;
    logic        req_ready, rd_valid, busy, xip_active, vcr_xip_n, sck, cs_n;
    logic [7:0]  rd_data;
    logic [3:0]  dq_out, dq_oe;
    logic [3:0]  dq_in = 4'b0;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;

    xip_read_ctrl #(.PWRUP_CYCLES(PWR)) u_dut (
        .clk(clk), .rst_n(rst_n), .strap_xip_boot(strap), .lanes(lanes),
        .dummy_clks(dummy), .req_valid(req_valid), .req_ready(req_ready),
        .req_cfg(req_cfg), .req_exit(req_exit), .req_addr(req_addr),
        .req_len(req_len), .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
        .xip_active(xip_active), .vcr_xip_n(vcr_xip_n), .sck(sck), .cs_n(cs_n),
        .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in));

    function automatic logic [7:0] mem_byte(input logic [23:0] a, input int k);
        return (a[7:0] + 8'(k)) ^ 8'hA5;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural flash model ----------------
    bit          m_xip, m_vcr3, m_had_cmd, m_conf;
    int          m_stage, m_cnt, m_dcnt, m_k, m_bitpos;
    logic [31:0] m_sh;
    logic [7:0]  m_cmd, m_wbyte, m_cur;
    logic [23:0] m_addr;

    function automatic int width();
        return (lanes == 2'd0) ? 1 : (lanes == 2'd1) ? 2 : 4;
    endfunction

    always @(negedge cs_n) begin
        m_stage = m_xip ? 1 : 0;
        m_cnt = 0; m_dcnt = 0; m_k = 0; m_bitpos = 0;
        m_had_cmd = 1'b0; m_cmd = 8'h00; m_conf = 1'b0; m_sh = '0;
    end

    always @(posedge sck) if (!cs_n) begin
        for (int i = width() - 1; i >= 0; i--) m_sh = {m_sh[30:0], dq_out[i]};
        m_cnt += width();
        case (m_stage)
            0: if (m_cnt == 8) begin
                m_cmd = m_sh[7:0]; m_had_cmd = 1'b1; m_cnt = 0;
                m_stage = (m_cmd == 8'h81) ? 4 : 1;
            end
            1: if (m_cnt == 24) begin
                m_addr = m_sh[23:0]; m_stage = 2; m_dcnt = 0;
            end
            2: begin
                if (m_dcnt == 0) m_conf = dq_out[0];
                m_dcnt++;
                if (m_dcnt == int'(dummy)) begin
                    m_stage = 3;
                    if (m_conf) begin m_xip = 1'b0; m_vcr3 = 1'b1; end
                    else if (!m_vcr3) m_xip = 1'b1;
                end
            end
            4: if (m_cnt == 8) begin
                m_wbyte = m_sh[7:0]; m_vcr3 = m_sh[3]; m_stage = 5;
            end
            default: ;
        endcase
    end

    always @(negedge sck) if (m_stage == 3) begin
        if (m_bitpos == 0) begin m_cur = mem_byte(m_addr, m_k); m_k++; end
        case (width())
            1: begin dq_in = {2'b00, m_cur[7], 1'b0}; m_cur = m_cur << 1; end
            2: begin dq_in = {2'b00, m_cur[7:6]};     m_cur = m_cur << 2; end
            default: begin dq_in = m_cur[7:4];        m_cur = m_cur << 4; end
        endcase
        m_bitpos = (m_bitpos + width()) % 8;
    end

    // ---------------- scoreboard monitor ----------------
    always @(negedge clk) if (rd_valid) begin
        if (exp_q.size() == 0) check("R9 unexpected byte", rd_data, 9'h100);
        else check("R9 read byte", rd_data, exp_q.pop_front());
    end

    // ---------------- driver ----------------
    task automatic do_reset(input bit s);
        rst_n = 1'b0; strap = s;
        m_xip = s; m_vcr3 = !s; m_stage = 5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 mode after reset", xip_active, s);
        check("R7 shadow bit after reset", vcr_xip_n, !s);
        check("R10 sck low at reset", sck, 0);
        check("R10 busy low at reset", busy, 0);
        repeat (PWR - 20) @(negedge clk);
        check("R1 cs_n high during delay", cs_n, 1);
        check("R1 not ready during delay", req_ready, 0);
        repeat (25) @(negedge clk);
        check("R1 ready after delay", req_ready, 1);
    endtask

    task automatic do_txn(input bit cfg, input logic [1:0] ln, input logic [3:0] dm,
                          input logic [23:0] a, input logic [7:0] len, input bit ex,
                          input bit exp_cmd, input bit exp_conf, input bit exp_xip);
        while (!req_ready) @(negedge clk);
        lanes = ln; dummy = dm;
        if (!cfg) for (int k = 0; k < int'(len); k++) exp_q.push_back(mem_byte(a, k));
        req_cfg = cfg; req_exit = ex; req_addr = a; req_len = len; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 busy while selected", busy, 1);
        check("R10 not ready while selected", req_ready, 0);
        while (!req_ready) @(negedge clk);
        check("R5 command presence", m_had_cmd, exp_cmd);
        if (exp_cmd) check("R2 command code", m_cmd, cfg ? 8'h81 : 8'h0B);
        if (cfg) begin
            check("R3 config data byte", m_wbyte, 8'hF3);
            check("R3 shadow bit cleared", vcr_xip_n, 0);
        end else begin
            check("R8 address", m_addr, a);
            check("R4 confirmation bit", m_conf, exp_conf);
            check("R9 all bytes returned", exp_q.size(), 0);
            check("R6 shadow bit", vcr_xip_n, exp_conf ? 1 : 0);
        end
        check("R5 mode flag", xip_active, exp_xip);
        check("R5 model agrees", m_xip, exp_xip);
    endtask

    initial begin
        do_reset(1'b0);
        do_txn(0, 2'd0, 4'd8,  24'h123456, 8'd3, 0, 1, 1, 0);  // R2 plain read
        do_txn(1, 2'd0, 4'd8,  24'h000000, 8'd1, 0, 1, 0, 0);  // R3 enable write
        do_txn(0, 2'd2, 4'd10, 24'hABCDEF, 8'd4, 0, 1, 0, 1);  // R4 confirm 0
        do_txn(0, 2'd2, 4'd10, 24'h00FF10, 8'd2, 0, 0, 0, 1);  // R5 command-less
        do_txn(0, 2'd1, 4'd6,  24'h7A0001, 8'd5, 0, 0, 0, 1);  // R8 two lines
        do_txn(0, 2'd0, 4'd1,  24'h0000F0, 8'd1, 0, 0, 0, 1);  // R8 one line
        do_txn(0, 2'd2, 4'd8,  24'h55AA33, 8'd3, 1, 0, 1, 0);  // R6 exit
        do_txn(0, 2'd1, 4'd8,  24'h010203, 8'd2, 0, 1, 1, 0);  // R6 command back
        do_reset(1'b1);
        do_txn(0, 2'd2, 4'd8,  24'hC0FFEE, 8'd3, 0, 0, 0, 1);  // R7 strap boot
        do_txn(0, 2'd0, 4'd4,  24'h000100, 8'd2, 1, 0, 1, 0);  // R6 exit
        do_txn(0, 2'd2, 4'd8,  24'hFEDCBA, 8'd2, 0, 1, 1, 0);  // R2 command back
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog R1-chain actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule